// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Processor Core

This block is a small processor core that retires one instruction on every rising clock edge. It holds the program counter, a 32-entry register file, the immediate extender, the ALU and the instruction decoders. It executes sixteen instructions in three fixed 32-bit formats:

- register-register arithmetic, logic and compare;
- the same operations with a 16-bit immediate;
- word load and word store;
- two conditional branches;
- one absolute jump.

The core drives a combinational instruction fetch port, addressed in bytes, and receives the instruction word in the same cycle. It also drives a data port with separate read and write strobes. Load data must be returned combinationally within the cycle. The store is taken by the memory on the clock edge that ends the cycle.

Internally the program counter is a 30-bit word address, and the byte address on the fetch port is that value with two zero bits appended. Branch and jump targets are built directly in word-address form. A synchronous active-high reset returns execution to address 0. Opcodes that are not recognised execute as no-operations.

Top module: `onecyc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is cleared, so `imem_addr` reads 0 in the following cycle.
- R2: Every instruction other than a taken branch or a jump advances `imem_addr` by 4.
- R3: An instruction with opcode field [31:26] = 0x00 writes register rd [15:11] with rs [25:21] op rt [20:16]. The op is chosen by bits [5:0]: add 0x20, sub 0x22, and 0x24, or 0x25, xor 0x26, slt 0x2A.
- R4: The immediate is bits [15:0], and the result goes to register rt. addi (0x08) and slti (0x0A) sign-extend it. andi (0x0C), ori (0x0D) and xori (0x0E) zero-extend it.
- R5: slt and slti compare as signed 32-bit values and write exactly 1 or 0.
- R6: lw (0x23) raises `dmem_rd` and puts rs + sign-extended imm16 on `dmem_addr`. It writes `dmem_rdata` into rt.
- R7: sw (0x2B) raises `dmem_wr`, with rs + sign-extended imm16 on `dmem_addr` and register rt on `dmem_wdata`. No other opcode raises `dmem_wr`, and sw writes no register.
- R8: beq (0x04) is taken when rs equals rt, and bne (0x05) is taken when they differ. A taken branch goes to the byte address of the next instruction plus 4 × sign-extended imm16. An untaken branch falls through to the next instruction.
- R9: j (0x02) sets the word address to the upper 4 bits of the incremented word address, followed by imm26 [25:0].
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: `dmem_rd` is high only for lw, and it is never high together with `dmem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_rd | output | 1 | Data read strobe, lw only |
| dmem_wr | output | 1 | Data write strobe, sw only |
| dmem_rdata | input | 32 | Load data for `dmem_addr` |

## Verification
The bench runs a program built to expose the following faults:

- **Wrong extender choice.** slti against 0xFFFF and andi of a negative register both give different stored values if the extender picks the wrong mode.
- **Unsigned compare.** A compare that is not signed turns the -3 < 5 result and the 5 < -1 result upside down.
- **Writable register 0.** A write to register 0 that sticks shows up as 7 in a later store.
- **Branch and jump target errors.** An inverted bne condition, an off-by-one target, or a jump target that takes its upper bits from the wrong place makes the fetch trace diverge. It also produces stores from instructions that should have been skipped.
- **Backward branch.** A final self-branch checks that the offset is sign-extended.

// File: rtl/onecyc_pkg.sv
`timescale 1ns/1ps
package onecyc_pkg;

    localparam int XLEN = 32;
    localparam int PCW  = XLEN - 2;   // word-address width

    // Primary opcode values (instruction bits [31:26])
    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_JMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_BNE  = 6'h05;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SLTI = 6'h0A;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_XORI = 6'h0E;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;

    // Function values for register-register instructions (bits [5:0])
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_ADD = 4'b0000,
        ALU_SUB = 4'b0010,
        ALU_AND = 4'b0100,
        ALU_OR  = 4'b0101,
        ALU_XOR = 4'b0110,
        ALU_SLT = 4'b1010
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;      // write the destination register
        logic    dst_is_rd;   // destination from [15:11] instead of [20:16]
        logic    imm_signed;  // sign- rather than zero-extend imm16
        logic    b_from_imm;  // second ALU operand is the immediate
        logic    mem_rd;
        logic    mem_wr;
        logic    wb_from_mem;
        logic    br_eq;
        logic    br_ne;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{default: '0, alu_op: ALU_ADD};

    function automatic logic [XLEN-1:0] extend16(input logic [15:0] imm,
                                                 input logic sgn);
        return {{(XLEN-16){sgn & imm[15]}}, imm};
    endfunction

endpackage

// File: rtl/onecyc_decode.sv
`timescale 1ns/1ps
module onecyc_decode
    import onecyc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = CTRL_NOP;
        case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_XOR:  ctrl.alu_op = ALU_XOR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_we = 1'b0;   // unknown function: no-op
                endcase
            end
            OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_XORI: begin
                ctrl.reg_we     = 1'b1;
                ctrl.b_from_imm = 1'b1;
                ctrl.imm_signed = (opcode == OPC_ADDI) || (opcode == OPC_SLTI);
                case (opcode)
                    OPC_SLTI: ctrl.alu_op = ALU_SLT;
                    OPC_ANDI: ctrl.alu_op = ALU_AND;
                    OPC_ORI:  ctrl.alu_op = ALU_OR;
                    OPC_XORI: ctrl.alu_op = ALU_XOR;
                    default:  ctrl.alu_op = ALU_ADD;
                endcase
            end
            OPC_LW: begin
                ctrl.reg_we      = 1'b1;
                ctrl.b_from_imm  = 1'b1;
                ctrl.imm_signed  = 1'b1;
                ctrl.mem_rd      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_SW: begin
                ctrl.b_from_imm = 1'b1;
                ctrl.imm_signed = 1'b1;
                ctrl.mem_wr     = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.br_eq  = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_BNE: begin
                ctrl.br_ne  = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JMP: ctrl.jump = 1'b1;
            default: ctrl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/onecyc_regfile.sv
`timescale 1ns/1ps
module onecyc_regfile #(
    parameter int WIDTH = 32,
    parameter int NREG  = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic [AW-1:0]    ra_a,
    input  logic [AW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);

    logic [WIDTH-1:0] cells [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        if (g == 0) begin : g_zero
            assign cells[g] = '0;               // hard-wired zero entry
        end else begin : g_reg
            logic [WIDTH-1:0] q;
            always_ff @(posedge clk) begin
                if (we && (wa == AW'(g))) q <= wd;
            end
            assign cells[g] = q;
        end
    end

    assign rd_a = cells[ra_a];
    assign rd_b = cells[ra_b];

endmodule

// File: rtl/onecyc_alu.sv
`timescale 1ns/1ps
module onecyc_alu
    import onecyc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/onecyc_core.sv
`timescale 1ns/1ps
module onecyc_core
    import onecyc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_rd,
    output logic        dmem_wr,
    input  logic [31:0] dmem_rdata
);

    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);
    localparam int JW   = 26;

    logic [PCW-1:0]  pc_q, pc_inc, pc_br, pc_nxt;
    logic [5:0]      f_op, f_fn;
    logic [RAW-1:0]  f_rs, f_rt, f_rd, wr_idx;
    logic [15:0]     f_imm;
    logic [JW-1:0]   f_jt;
    ctrl_t           ctl;
    logic [XLEN-1:0] rs_val, rt_val, imm_x, alu_b, alu_y, wb_val;
    logic            alu_z, take_br;

    assign f_op  = imem_rdata[31:26];
    assign f_rs  = imem_rdata[25:21];
    assign f_rt  = imem_rdata[20:16];
    assign f_rd  = imem_rdata[15:11];
    assign f_fn  = imem_rdata[5:0];
    assign f_imm = imem_rdata[15:0];
    assign f_jt  = imem_rdata[JW-1:0];

    onecyc_decode u_dec (
        .opcode (f_op),
        .funct  (f_fn),
        .ctrl   (ctl)
    );

    assign wr_idx = ctl.dst_is_rd ? f_rd : f_rt;

    onecyc_regfile #(.WIDTH(XLEN), .NREG(NREG)) u_rf (
        .clk  (clk),
        .ra_a (f_rs),
        .ra_b (f_rt),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (ctl.reg_we),
        .wa   (wr_idx),
        .wd   (wb_val)
    );

    assign imm_x = extend16(f_imm, ctl.imm_signed);
    assign alu_b = ctl.b_from_imm ? imm_x : rt_val;

    onecyc_alu #(.WIDTH(XLEN)) u_alu (
        .op   (ctl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_z)
    );

    assign wb_val = ctl.wb_from_mem ? dmem_rdata : alu_y;

    // Next-PC, all in word-address form
    assign pc_inc  = pc_q + 1'b1;
    assign pc_br   = pc_inc + {{(PCW-16){f_imm[15]}}, f_imm};
    assign take_br = (ctl.br_eq & alu_z) | (ctl.br_ne & ~alu_z);

    always_comb begin
        if (ctl.jump)     pc_nxt = {pc_inc[PCW-1:JW], f_jt};
        else if (take_br) pc_nxt = pc_br;
        else              pc_nxt = pc_inc;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nxt;
    end

    assign imem_addr  = {pc_q, 2'b00};
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_rd    = ctl.mem_rd;
    assign dmem_wr    = ctl.mem_wr;

endmodule

// File: rtl/onecyc_core_chk.sv
`timescale 1ns/1ps
module onecyc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_rdata,
    input logic        dmem_rd,
    input logic        dmem_wr
);

    logic [5:0]  op;
    logic [31:0] seq_addr, jump_dest;
    logic        straight;

    assign op        = imem_rdata[31:26];
    assign seq_addr  = imem_addr + 32'd4;
    assign jump_dest = {seq_addr[31:28], imem_rdata[25:0], 2'b00};
    assign straight  = (op == 6'h00) || (op == 6'h08) || (op == 6'h0A) ||
                       (op == 6'h0C) || (op == 6'h0D) || (op == 6'h0E) ||
                       (op == 6'h23) || (op == 6'h2B);

    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> (imem_addr == 32'd0));

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
        straight |=> (imem_addr == $past(seq_addr)));

    assert_store_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        dmem_wr == (op == 6'h2B));

    assert_jump_dest_R9: assert property (@(posedge clk) disable iff (rst)
        (op == 6'h02) |=> (imem_addr == $past(jump_dest)));

    assert_load_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        dmem_rd == (op == 6'h23));

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(dmem_rd && dmem_wr));

endmodule

bind onecyc_core onecyc_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_rd    (dmem_rd),
    .dmem_wr    (dmem_wr)
);

// File: tb/onecyc_core_bench.sv
`timescale 1ns/1ps
module onecyc_core_bench;

    function automatic logic [31:0] enc_r(input int rs, input int rt,
                                          input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                          input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'h02, tgt};
    endfunction

    localparam int NPROG = 35;
    localparam logic [31:0] PROG [NPROG] = '{
        enc_i(6'h08, 0, 1, 16'd5),       //  0 addi r1 = 5
        enc_i(6'h08, 0, 2, 16'hFFFD),    //  1 addi r2 = -3
        enc_r(1, 2, 3, 6'h20),           //  2 add  r3 = 2
        enc_i(6'h2B, 0, 3, 16'd0),       //  3 sw r3 -> 0
        enc_r(2, 1, 4, 6'h22),           //  4 sub  r4 = -8
        enc_i(6'h2B, 0, 4, 16'd4),       //  5 sw r4 -> 4
        enc_r(2, 1, 5, 6'h2A),           //  6 slt  r5 = (-3 < 5) = 1
        enc_i(6'h2B, 0, 5, 16'd8),       //  7 sw r5 -> 8
        enc_i(6'h0A, 1, 6, 16'hFFFF),    //  8 slti r6 = (5 < -1) = 0
        enc_i(6'h2B, 0, 6, 16'd12),      //  9 sw r6 -> 12
        enc_i(6'h0D, 0, 7, 16'h8000),    // 10 ori  r7 = 0x8000
        enc_i(6'h2B, 0, 7, 16'd16),      // 11 sw r7 -> 16
        enc_i(6'h0C, 2, 8, 16'hFFFF),    // 12 andi r8 = 0xFFFD
        enc_i(6'h0E, 8, 9, 16'h00FF),    // 13 xori r9 = 0xFF02
        enc_i(6'h2B, 0, 9, 16'd20),      // 14 sw r9 -> 20
        enc_r(1, 7, 10, 6'h25),          // 15 or   r10 = 0x8005
        enc_r(10, 2, 11, 6'h26),         // 16 xor  r11 = 0xFFFF7FF8
        enc_r(11, 9, 11, 6'h24),         // 17 and  r11 = 0x7F00
        enc_i(6'h2B, 0, 11, 16'd24),     // 18 sw r11 -> 24
        enc_i(6'h08, 0, 0, 16'd7),       // 19 addi r0 = 7 (dropped)
        enc_i(6'h2B, 0, 0, 16'd28),      // 20 sw r0 -> 28
        enc_i(6'h23, 0, 12, 16'd0),      // 21 lw r12 <- 0
        enc_i(6'h2B, 0, 12, 16'd32),     // 22 sw r12 -> 32
        enc_i(6'h04, 1, 2, 16'd5),       // 23 beq not taken
        enc_i(6'h05, 1, 2, 16'd2),       // 24 bne taken -> 27
        enc_i(6'h2B, 0, 1, 16'd36),      // 25 skipped
        enc_i(6'h2B, 0, 1, 16'd36),      // 26 skipped
        enc_i(6'h04, 1, 1, 16'd1),       // 27 beq taken -> 29
        enc_i(6'h2B, 0, 1, 16'd40),      // 28 skipped
        enc_j(26'd32),                   // 29 j -> 32
        enc_i(6'h2B, 0, 1, 16'd44),      // 30 skipped
        enc_i(6'h2B, 0, 1, 16'd44),      // 31 skipped
        enc_i(6'h05, 1, 1, 16'd3),       // 32 bne not taken
        enc_i(6'h2B, 0, 2, 16'd44),      // 33 sw r2 -> 44
        enc_i(6'h04, 0, 0, 16'hFFFF)     // 34 beq to itself
    };

    localparam int NTRACE = 32;
    localparam logic [29:0] EXP_PC [NTRACE] = '{
        30'd0,  30'd1,  30'd2,  30'd3,  30'd4,  30'd5,  30'd6,  30'd7,
        30'd8,  30'd9,  30'd10, 30'd11, 30'd12, 30'd13, 30'd14, 30'd15,
        30'd16, 30'd17, 30'd18, 30'd19, 30'd20, 30'd21, 30'd22, 30'd23,
        30'd24, 30'd27, 30'd29, 30'd32, 30'd33, 30'd34, 30'd34, 30'd34
    };

    localparam int NST = 10;
    localparam logic [31:0] ST_ADDR [NST] = '{
        32'd0, 32'd4, 32'd8, 32'd12, 32'd16, 32'd20, 32'd24, 32'd28, 32'd32, 32'd44
    };
    localparam logic [31:0] ST_DATA [NST] = '{
        32'h2, 32'hFFFF_FFF8, 32'h1, 32'h0, 32'h0000_8000, 32'h0000_FF02,
        32'h0000_7F00, 32'h0, 32'h2, 32'hFFFF_FFFD
    };

    function automatic string st_tag(input int i);
        case (i)
            2, 3:    return "R5";
            4, 5:    return "R4";
            7:       return "R10";
            8:       return "R6";
            9:       return "R8";
            default: return "R3";
        endcase
    endfunction

    function automatic string pc_tag(input int k);
        if (k == 27) return "R9";
        if (k == 25 || k == 26 || k == 28 || k >= 30) return "R8";
        return "R2";
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_rd, dmem_wr;
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    onecyc_core u_onecyc_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_wr) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = (i < NPROG) ? PROG[i] : 32'h0;
            dmem[i] = 32'h0;
        end
    end

    initial begin
        int si;
        si = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'd0, "R1", imem_addr, 32'd0);   // reset state
        rst = 1'b0;
        #1;
        for (int k = 0; k < NTRACE; k++) begin
            check(imem_addr == {EXP_PC[k], 2'b00}, pc_tag(k),
                  imem_addr, {EXP_PC[k], 2'b00});
            // R11: read strobe only on the lw at word 21, never with write
            check(dmem_rd == (EXP_PC[k] == 30'd21) && !(dmem_rd && dmem_wr),
                  "R11", {30'd0, dmem_rd, dmem_wr},
                  {30'd0, (EXP_PC[k] == 30'd21), 1'b0});
            if (dmem_wr) begin
                if (si < NST) begin
                    check(dmem_addr == ST_ADDR[si], "R7", dmem_addr, ST_ADDR[si]);
                    check(dmem_wdata == ST_DATA[si], st_tag(si),
                          dmem_wdata, ST_DATA[si]);
                end else begin
                    check(1'b0, "R7", dmem_addr, 32'hFFFF_FFFF);  // store from skipped code
                end
                si++;
            end
            @(negedge clk);
            #1;
        end
        check(si == NST, "R7", 32'(si), 32'(NST));
        // R6: the loaded word is also visible in data memory word 8
        check(dmem[8] == 32'h2, "R6", dmem[8], 32'h2);
        // Mid-run reset returns to address 0
        rst = 1'b1;
        @(negedge clk);
        #1;
        check(imem_addr == 32'd0, "R1", imem_addr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(imem_addr == 32'd4, "R2", imem_addr, 32'd4);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule